// File: doc/BRIEF.md
# Isolated I/O Port Strobe Decoder

This block turns an isolated I/O bus cycle into strobes for three ports. The bus is 16 bits wide, split into a low byte bank and a high byte bank. The inputs are the port address, two active-low bank enables and active-low I/O read and I/O write commands. There are no memory commands on these pins, so memory cycles cannot fire a strobe.

Two 8-bit output latches form an even/odd pair at a base address. One latch sits in each bank, and each gets its own write clock, steered by its bank enable. A byte write reaches one latch. A word write to the even address clocks both latches, so the pair also works as one 16-bit output port.

One 16-bit input port sits at a second even/odd pair. It gets a single read enable that drives both byte buffers, and the bank enables play no part in it. A parameter chooses one of two decode modes:
- **Fixed mode:** only the low address byte is compared.
- **Full mode:** all sixteen address bits are compared.

The decoder is purely combinational.

Top module: `iodec_port_strobes`

## Requirements
- R1: With FULL_DECODE=0, a port matches when address bits 7..1 equal the base's bits 7..1. Address bits 15..8 have no effect on any output.
- R2: With FULL_DECODE=1, a port matches only when address bits 15..1 equal the base's bits 15..1.
- R3: `lo_wr_n` is low exactly when all three hold: the write command alone is active, the address selects the output pair at OUT_BASE (even, low bank), and `low_be_n` is low.
- R4: `hi_wr_n` is low exactly when all three hold: the write command alone is active, the address selects the output pair at OUT_BASE, and `high_be_n` is low. Bit 0 of the address is ignored, so that a byte write to OUT_BASE+1 uses the high bank.
- R5: A write to OUT_BASE with both bank enables low drives `lo_wr_n` and `hi_wr_n` low together.
- R6: `in_rd_n` is low exactly when the read command alone is active and the address selects the pair at IN_BASE. The value is the same for all four bank-enable combinations.
- R7: A read command never lowers a write strobe. A write command never lowers `in_rd_n`.
- R8: With both `io_rd_n` and `io_wr_n` high, all strobes are high and `cmd_err` is low.
- R9: With both commands low, `cmd_err` is high and all strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_rd_n | input | 1 | I/O read command, active low |
| io_wr_n | input | 1 | I/O write command, active low |
| port_addr | input | 16 | I/O port address |
| low_be_n | input | 1 | Low byte bank enable, active low (address bit 0 low) |
| high_be_n | input | 1 | High byte bank enable, active low |
| lo_wr_n | output | 1 | Write clock for the low-bank 8-bit latch, active low |
| hi_wr_n | output | 1 | Write clock for the high-bank 8-bit latch, active low |
| in_rd_n | output | 1 | Read enable for both bytes of the 16-bit input buffer, active low |
| cmd_err | output | 1 | High when read and write are asserted together |

## Verification
Every address from 0 to FFFFH is swept once under a write and once under a read. The bank enables vary with the address, so each decode mode shows exactly which addresses hit the output pair and the input pair.

A second sweep covers every low address byte with all four bank-enable codes and all four command codes. The upper byte is scrambled on each step. In fixed mode this shows the upper byte has no effect, while the full-decode instance turns the same patterns into misses. The sweep also separates byte writes from word writes, read-enable behaviour that ignores the banks, the idle case and the conflict case.

// File: rtl/iodec_pkg.sv
package iodec_pkg;

    localparam int IO_ADDR_W  = 16;
    localparam int FIXED_W    = 8;

    typedef logic [IO_ADDR_W-1:0] io_addr_t;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_CLASH = 2'b11
    } io_cmd_e;

    typedef struct packed {
        logic rd_go;
        logic wr_go;
        logic clash;
    } cmd_qual_t;

    typedef struct packed {
        logic lo_wr;
        logic hi_wr;
        logic rd;
    } strobe_set_t;

    // Mask that keeps the compared address bits; bit 0 is always dropped
    // because it only selects the byte inside an even/odd pair.
    function automatic io_addr_t pair_mask(input bit full);
        io_addr_t m;
        m = full ? '1 : io_addr_t'((1 << FIXED_W) - 1);
        m[0] = 1'b0;
        return m;
    endfunction

endpackage

// File: rtl/iodec_cmd_qual.sv
module iodec_cmd_qual
    import iodec_pkg::*;
(
    input  logic      rd_n,
    input  logic      wr_n,
    output cmd_qual_t qual
);
    io_cmd_e cmd;

    always_comb begin
        cmd = io_cmd_e'({~wr_n, ~rd_n});
        qual = '0;
        unique case (cmd)
            CMD_READ:  qual.rd_go = 1'b1;
            CMD_WRITE: qual.wr_go = 1'b1;
            CMD_CLASH: qual.clash = 1'b1;
            default:   qual = '0;
        endcase
    end
endmodule

// File: rtl/iodec_addr_match.sv
module iodec_addr_match
    import iodec_pkg::*;
#(
    parameter bit       FULL_DECODE = 1'b0,
    parameter io_addr_t BASE        = 16'h0040
) (
    input  io_addr_t addr,
    output logic     hit
);
    localparam io_addr_t MASK = pair_mask(FULL_DECODE);
    localparam io_addr_t KEY  = BASE & MASK;

    generate
        if (FULL_DECODE) begin : g_full
            assign hit = ((addr & MASK) == KEY);
        end else begin : g_fixed
            logic [FIXED_W-1:0] low_byte;
            logic               unused_hi;
            assign low_byte  = addr[FIXED_W-1:0];
            assign unused_hi = ^addr[IO_ADDR_W-1:FIXED_W];
            assign hit = ((low_byte & MASK[FIXED_W-1:0]) == KEY[FIXED_W-1:0]);
        end
    endgenerate
endmodule

// File: rtl/iodec_bank_steer.sv
module iodec_bank_steer
    import iodec_pkg::*;
(
    input  cmd_qual_t   qual,
    input  logic        out_hit,
    input  logic        in_hit,
    input  logic        low_be_n,
    input  logic        high_be_n,
    output strobe_set_t act
);
    always_comb begin
        act = '0;
        if (!qual.clash) begin
            act.lo_wr = qual.wr_go & out_hit & ~low_be_n;
            act.hi_wr = qual.wr_go & out_hit & ~high_be_n;
            act.rd    = qual.rd_go & in_hit;
        end
    end
endmodule

// File: rtl/iodec_port_strobes.sv
module iodec_port_strobes
    import iodec_pkg::*;
#(
    parameter bit       FULL_DECODE = 1'b0,
    parameter io_addr_t OUT_BASE    = 16'h0040,
    parameter io_addr_t IN_BASE     = 16'h0064
) (
    input  logic        io_rd_n,
    input  logic        io_wr_n,
    input  logic [15:0] port_addr,
    input  logic        low_be_n,
    input  logic        high_be_n,
    output logic        lo_wr_n,
    output logic        hi_wr_n,
    output logic        in_rd_n,
    output logic        cmd_err
);
    cmd_qual_t   qual;
    strobe_set_t act;
    logic        out_hit;
    logic        in_hit;

    iodec_cmd_qual u_cmd (
        .rd_n (io_rd_n),
        .wr_n (io_wr_n),
        .qual (qual)
    );

    iodec_addr_match #(.FULL_DECODE(FULL_DECODE), .BASE(OUT_BASE)) u_out_match (
        .addr (port_addr),
        .hit  (out_hit)
    );

    iodec_addr_match #(.FULL_DECODE(FULL_DECODE), .BASE(IN_BASE)) u_in_match (
        .addr (port_addr),
        .hit  (in_hit)
    );

    iodec_bank_steer u_steer (
        .qual      (qual),
        .out_hit   (out_hit),
        .in_hit    (in_hit),
        .low_be_n  (low_be_n),
        .high_be_n (high_be_n),
        .act       (act)
    );

    assign lo_wr_n = ~act.lo_wr;
    assign hi_wr_n = ~act.hi_wr;
    assign in_rd_n = ~act.rd;
    assign cmd_err = qual.clash;
endmodule

// File: rtl/iodec_port_strobes_chk.sv
module iodec_port_strobes_chk (
    input logic        io_rd_n,
    input logic        io_wr_n,
    input logic [15:0] port_addr,
    input logic        low_be_n,
    input logic        high_be_n,
    input logic        lo_wr_n,
    input logic        hi_wr_n,
    input logic        in_rd_n,
    input logic        cmd_err
);
    logic known;
    assign known = !$isunknown({io_rd_n, io_wr_n, port_addr, low_be_n, high_be_n,
                                lo_wr_n, hi_wr_n, in_rd_n, cmd_err});

    always_comb begin
        if (known) begin
            AST_LO_NEEDS_LOW_BANK: assert (lo_wr_n || !low_be_n);                       // R3
            AST_HI_NEEDS_HIGH_BANK: assert (hi_wr_n || !high_be_n);                     // R4
            AST_RD_NO_WR_STROBE: assert (io_rd_n || (lo_wr_n && hi_wr_n));              // R7
            AST_WR_NO_RD_STROBE: assert (io_wr_n || in_rd_n);                           // R7
            AST_IDLE_QUIET: assert (!(io_rd_n && io_wr_n) ||
                                    (lo_wr_n && hi_wr_n && in_rd_n && !cmd_err));       // R8
            AST_CLASH_FLAG: assert (!(!io_rd_n && !io_wr_n) ||
                                    (cmd_err && lo_wr_n && hi_wr_n && in_rd_n));        // R9
        end
    end
endmodule

bind iodec_port_strobes iodec_port_strobes_chk u_chk (
    .io_rd_n   (io_rd_n),
    .io_wr_n   (io_wr_n),
    .port_addr (port_addr),
    .low_be_n  (low_be_n),
    .high_be_n (high_be_n),
    .lo_wr_n   (lo_wr_n),
    .hi_wr_n   (hi_wr_n),
    .in_rd_n   (in_rd_n),
    .cmd_err   (cmd_err)
);

// File: tb/iodec_port_strobes_tb.sv
module iodec_port_strobes_tb;
    localparam int OUTB = 'h40;
    localparam int INB  = 'h64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_rd_n = 1'b1, io_wr_n = 1'b1;
    logic [15:0] port_addr = '0;
    logic        low_be_n = 1'b1, high_be_n = 1'b1;
    logic        f_lo, f_hi, f_rd, f_err;
    logic        w_lo, w_hi, w_rd, w_err;
    int          checks = 0, failures = 0, cycles = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    iodec_port_strobes #(.FULL_DECODE(1'b0), .OUT_BASE(16'h0040), .IN_BASE(16'h0064)) u_dut (
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .port_addr(port_addr),
        .low_be_n(low_be_n), .high_be_n(high_be_n),
        .lo_wr_n(f_lo), .hi_wr_n(f_hi), .in_rd_n(f_rd), .cmd_err(f_err));

    iodec_port_strobes #(.FULL_DECODE(1'b1), .OUT_BASE(16'h0040), .IN_BASE(16'h0064)) u_dut_full (
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .port_addr(port_addr),
        .low_be_n(low_be_n), .high_be_n(high_be_n),
        .lo_wr_n(w_lo), .hi_wr_n(w_hi), .in_rd_n(w_rd), .cmd_err(w_err));

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s addr=%h rd_n=%b wr_n=%b lbe=%b hbe=%b actual=%b expected=%b",
                     req, port_addr, io_rd_n, io_wr_n, low_be_n, high_be_n, act, exp);
        end
    endtask

    // Behavioural reference: integer arithmetic on port numbers.
    task automatic compare_all();
        int  a;
        bit  wr_only, rd_only, both;
        bit  out_f, in_f, out_w, in_w;
        a = int'(port_addr);
        wr_only = !io_wr_n && io_rd_n;
        rd_only = !io_rd_n && io_wr_n;
        both    = !io_rd_n && !io_wr_n;
        out_f = ((a % 256) / 2) == ((OUTB % 256) / 2);   // R1
        in_f  = ((a % 256) / 2) == ((INB % 256) / 2);    // R1
        out_w = (a / 2) == (OUTB / 2);                   // R2
        in_w  = (a / 2) == (INB / 2);                    // R2
        check("R3 fixed lo_wr_n", f_lo, !(wr_only && out_f && !low_be_n));
        check("R4 fixed hi_wr_n", f_hi, !(wr_only && out_f && !high_be_n));
        check("R6 fixed in_rd_n", f_rd, !(rd_only && in_f));
        check("R9 fixed cmd_err", f_err, both);
        check("R2 full lo_wr_n", w_lo, !(wr_only && out_w && !low_be_n));
        check("R2 full hi_wr_n", w_hi, !(wr_only && out_w && !high_be_n));
        check("R2 full in_rd_n", w_rd, !(rd_only && in_w));
        check("R9 full cmd_err", w_err, both);
    endtask

    task automatic apply(input int a, input int be, input int cmd);
        @(posedge clk);
        port_addr = 16'(a);
        low_be_n  = be[0];
        high_be_n = be[1];
        io_rd_n   = cmd[0];
        io_wr_n   = cmd[1];
        @(negedge clk);
        compare_all();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // R8: idle state with no command
        @(negedge clk);
        check("R8 idle lo_wr_n", f_lo, 1'b1);
        check("R8 idle hi_wr_n", f_hi, 1'b1);
        check("R8 idle in_rd_n", f_rd, 1'b1);
        check("R8 idle cmd_err", f_err, 1'b0);
        // R5: word write to the even base address fires both clocks together
        apply(OUTB, 0, 1);
        check("R5 word lo_wr_n", f_lo, 1'b0);
        check("R5 word hi_wr_n", f_hi, 1'b0);
        // R4: byte write to the odd port uses the high bank only
        apply(OUTB + 1, 1, 1);
        check("R4 odd byte hi_wr_n", f_hi, 1'b0);
        check("R4 odd byte lo_wr_n", f_lo, 1'b1);
        // R1: upper byte ignored in fixed mode, honoured in full mode
        apply('hA564, 3, 2);
        check("R1 fixed upper ignored", f_rd, 1'b0);
        check("R2 full upper compared", w_rd, 1'b1);
        // R6/R7: full sweep, write then read, bank enables vary with address
        for (int pass = 0; pass < 2; pass++) begin
            for (int a = 0; a < 65536; a++) begin
                apply(a, (a / 3) % 4, pass == 0 ? 1 : 2);
            end
        end
        // R1/R9/R8: every low byte x bank code x command code, scrambled upper byte
        for (int lb = 0; lb < 256; lb++) begin
            for (int be = 0; be < 4; be++) begin
                for (int c = 0; c < 4; c++) begin
                    apply((((lb * 37 + be * 11 + c) % 256) << 8) | lb, be, c);
                end
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule